// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a small two-way set-associative data cache placed between a CPU load/store port and a simple quadword-wide memory port. It accepts one access at a time. An access can be a byte, halfword, word, doubleword or quadword. It looks the physical address up in both ways. On a hit it serves the access from its own storage, and a write marks the line dirty. On a miss it chooses a candidate way from one replacement bit per way and per set. If that candidate is clean, the block fills it from memory in four beats and then serves the access from the new line.

A dirty candidate is never written back. Instead the access goes uncached: a write is sent straight to memory under a byte-enable mask, and a read returns the memory quadword directly. A single enable input turns caching off completely. While it is low, every access takes the uncached path, including accesses that would hit. Both ports use a valid/ready handshake where a transfer happens in any cycle that has both signals high.

Top module: `wb_dcache`

## Requirements
- R1: After reset, every line is invalid, `cpu_req_ready` is 1, and `cpu_rsp_valid` and `mem_req_valid` are 0. The first access to any address is therefore a miss.
- R2: Address bits [11:6] pick one of 64 sets. Bits [31:12] form the tag. Bits [5:4] pick one of four 16-byte quadwords in a 64-byte line. Bits [3:0] pick the first byte lane.
- R3: A hit needs a valid way whose tag equals address bits [31:12], with way 0 checked first. A hit is answered on the second rising edge after acceptance and causes no memory request.
- R4: On a miss with a clean candidate, the line is filled by four memory reads at line base + 0, 16, 32 and 48, in that order. The way is then valid and clean, and the access is served from it.
- R5: On a miss, the candidate way is the XOR of the two ways' replacement bits for that set. Each fill inverts the filled way's bit. As a result, successive misses to one set that start from reset use way 0, then way 1, then way 0, and so on.
- R6: A cached write sets the line's dirty flag. It updates only the lanes given by the size code (0=1 byte, 1=2, 2=4, 3=8, 4 to 7=16) starting at lane bits [3:0], taking the data from the low bits of `cpu_req_wdata`. All other lanes keep their contents.
- R7: A miss whose candidate way is valid and dirty does no fill and leaves the cache unchanged. A write becomes one memory write to the quadword address (bits [3:0] zero) with the R6 byte-enable mask. A read becomes one memory read whose data is returned.
- R8: While `cache_en` is 0, every access takes the R7 uncached path, including addresses that would hit.
- R9: Read data is shifted right so that the first addressed byte lands in bits [7:0]. Bits above the access size are 0. A write returns all-zero data.
- R10: A request is accepted only while the block is idle. `cpu_rsp_valid` is a one-cycle pulse per accepted request. The response cycle may also accept the next request. `mem_req_valid` and its address stay steady until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Caching enable; 0 sends all accesses uncached |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Block can accept a CPU request |
| cpu_req_write | input | 1 | 1 for a store, 0 for a load |
| cpu_req_size | input | 3 | Access size code (see R6) |
| cpu_req_addr | input | 32 | Physical byte address |
| cpu_req_wdata | input | 128 | Store data, right-aligned |
| cpu_rsp_valid | output | 1 | One-cycle response strobe |
| cpu_rsp_rdata | output | 128 | Load data, right-aligned and size-masked |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for a memory write |
| mem_req_addr | output | 32 | Quadword-aligned memory address |
| mem_req_be | output | 16 | Byte enables for a memory write |
| mem_req_wdata | output | 128 | Memory write data, lane-aligned |
| mem_rsp_valid | input | 1 | Memory read data present |
| mem_rsp_rdata | input | 128 | Memory read quadword |

## Verification
Two events can fall in the same cycle: the response pulse for one access and the acceptance of the next CPU request. The bench provokes this by presenting a second request in the very cycle the first response appears, then chaining a read hit into a write hit on the same line. It checks that ready is high in that cycle, that the response drops the following cycle, and that both results and the merged line contents match the reference model. The memory side is also stressed by holding ready low on alternate cycles during a fill, which checks that requests are held and that the four beats still land in order.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    localparam int ADDR_W   = 32;
    localparam int QW_BYTES = 16;
    localparam int QW_BITS  = QW_BYTES * 8;
    localparam int OFF_W    = $clog2(QW_BYTES);

    typedef enum logic [2:0] {
        SZ_BYTE = 3'd0,
        SZ_HALF = 3'd1,
        SZ_WORD = 3'd2,
        SZ_DWRD = 3'd3,
        SZ_QUAD = 3'd4
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_BYP_REQ,
        ST_BYP_WAIT
    } ctl_state_e;

    // byte lanes touched by an access of a given size at a given offset
    function automatic logic [QW_BYTES-1:0] lane_mask(acc_size_e sz, logic [OFF_W-1:0] off);
        logic [QW_BYTES-1:0] base;
        case (sz)
            SZ_BYTE: base = 16'h0001;
            SZ_HALF: base = 16'h0003;
            SZ_WORD: base = 16'h000F;
            SZ_DWRD: base = 16'h00FF;
            default: base = 16'hFFFF;
        endcase
        return base << off;
    endfunction

    function automatic logic [QW_BITS-1:0] bit_mask(logic [QW_BYTES-1:0] be);
        logic [QW_BITS-1:0] m;
        for (int b = 0; b < QW_BYTES; b++) m[8*b +: 8] = {8{be[b]}};
        return m;
    endfunction

    // move addressed bytes down to lane 0 and clear everything above the size
    function automatic logic [QW_BITS-1:0] align_read(logic [QW_BITS-1:0] qw, acc_size_e sz,
                                                      logic [OFF_W-1:0] off);
        logic [QW_BITS-1:0] sh;
        sh = qw >> {off, 3'b000};
        return sh & bit_mask(lane_mask(sz, '0));
    endfunction

endpackage

// File: rtl/dcache_tags.sv
module dcache_tags #(
    parameter int SETS  = 64,
    parameter int TAG_W = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(SETS)-1:0]  idx,
    input  logic [TAG_W-1:0]         lk_tag,
    output logic [1:0]               hit,
    output logic                     victim,
    output logic                     victim_dirty,
    input  logic                     fill_we,
    input  logic                     fill_way,
    input  logic                     dirty_we,
    input  logic                     dirty_way
);
    localparam int WAYS = 2;

    logic [TAG_W-1:0]            tag_q [WAYS][SETS];
    logic [WAYS-1:0][SETS-1:0]   vld_q;
    logic [WAYS-1:0][SETS-1:0]   drt_q;
    logic [WAYS-1:0][SETS-1:0]   rpl_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit[w] = vld_q[w][idx] && (tag_q[w][idx] == lk_tag);
    end

    assign victim       = rpl_q[0][idx] ^ rpl_q[1][idx];
    assign victim_dirty = vld_q[victim][idx] & drt_q[victim][idx];

    always_ff @(posedge clk) begin
        for (int w = 0; w < WAYS; w++) begin
            if (fill_we && fill_way == w[0]) tag_q[w][idx] <= lk_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            drt_q <= '0;
            rpl_q <= '0;
        end else begin
            for (int w = 0; w < WAYS; w++) begin
                if (fill_we && fill_way == w[0]) begin
                    vld_q[w][idx] <= 1'b1;
                    drt_q[w][idx] <= 1'b0;
                    rpl_q[w][idx] <= ~rpl_q[w][idx];
                end else if (dirty_we && dirty_way == w[0]) begin
                    drt_q[w][idx] <= 1'b1;
                end
            end
        end
    end

    // R3: a tag may live in at most one way of a set
    p_hit_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

    // R4: a completed fill leaves the way valid and clean
    p_fill_clean_r4: assert property (@(posedge clk) disable iff (rst)
        fill_we |=> vld_q[$past(fill_way)][$past(idx)] && !drt_q[$past(fill_way)][$past(idx)]);

    // R5: the filled way's replacement bit flips
    p_repl_flip_r5: assert property (@(posedge clk) disable iff (rst)
        fill_we |=> rpl_q[$past(fill_way)][$past(idx)] != $past(rpl_q[fill_way][idx]));

    // R6: a cached write leaves the line dirty
    p_dirty_set_r6: assert property (@(posedge clk) disable iff (rst)
        dirty_we |=> drt_q[$past(dirty_way)][$past(idx)]);

endmodule

// File: rtl/dcache_data.sv
module dcache_data #(
    parameter int IDX_W  = 6,
    parameter int BEAT_W = 2
) (
    input  logic               clk,
    input  logic               rd_way,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [BEAT_W-1:0]  rd_beat,
    output logic [127:0]       rd_data,
    input  logic               we,
    input  logic               wr_way,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [BEAT_W-1:0]  wr_beat,
    input  logic [15:0]        wr_be,
    input  logic [127:0]       wr_data
);
    localparam int ROW_W = 1 + IDX_W + BEAT_W;
    localparam int DEPTH = 1 << ROW_W;

    logic [127:0] arr [DEPTH];

    logic [ROW_W-1:0] rd_row, wr_row;
    assign rd_row  = {rd_way, rd_idx, rd_beat};
    assign wr_row  = {wr_way, wr_idx, wr_beat};
    assign rd_data = arr[rd_row];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < 16; b++) begin
                if (wr_be[b]) arr[wr_row][8*b +: 8] <= wr_data[8*b +: 8];
            end
        end
    end

endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
    import dcache_pkg::*;
#(
    parameter int SETS       = 64,
    parameter int LINE_BYTES = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cache_en,
    input  logic         cpu_req_valid,
    output logic         cpu_req_ready,
    input  logic         cpu_req_write,
    input  logic [2:0]   cpu_req_size,
    input  logic [31:0]  cpu_req_addr,
    input  logic [127:0] cpu_req_wdata,
    output logic         cpu_rsp_valid,
    output logic [127:0] cpu_rsp_rdata,
    output logic         mem_req_valid,
    input  logic         mem_req_ready,
    output logic         mem_req_write,
    output logic [31:0]  mem_req_addr,
    output logic [15:0]  mem_req_be,
    output logic [127:0] mem_req_wdata,
    input  logic         mem_rsp_valid,
    input  logic [127:0] mem_rsp_rdata
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int LINE_W = $clog2(LINE_BYTES);
    localparam int BEATS  = LINE_BYTES / QW_BYTES;
    localparam int BEAT_W = $clog2(BEATS);
    localparam int TAG_W  = ADDR_W - IDX_W - LINE_W;

    ctl_state_e          st_q, st_d;
    logic [ADDR_W-1:0]   a_q;
    logic                w_q;
    acc_size_e           sz_q;
    logic [QW_BITS-1:0]  wd_q;
    logic [BEAT_W-1:0]   beat_q, beat_d;
    logic                fway_q, fway_d;
    logic                rsp_v_q, rsp_v_d;
    logic [QW_BITS-1:0]  rsp_d_q, rsp_d_d;

    logic [IDX_W-1:0]    idx;
    logic [TAG_W-1:0]    tag;
    logic [BEAT_W-1:0]   qsel;
    logic [OFF_W-1:0]    off;
    logic [QW_BYTES-1:0] be;
    logic [QW_BITS-1:0]  wshift;

    assign idx    = a_q[LINE_W +: IDX_W];
    assign tag    = a_q[ADDR_W-1 -: TAG_W];
    assign qsel   = a_q[OFF_W +: BEAT_W];
    assign off    = a_q[OFF_W-1:0];
    assign be     = lane_mask(sz_q, off);
    assign wshift = wd_q << {off, 3'b000};

    logic [1:0] hit;
    logic       victim, victim_dirty, hway;
    logic       tag_fill, tag_dirty;

    assign hway = ~hit[0];

    dcache_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk          (clk),
        .rst          (rst),
        .idx          (idx),
        .lk_tag       (tag),
        .hit          (hit),
        .victim       (victim),
        .victim_dirty (victim_dirty),
        .fill_we      (tag_fill),
        .fill_way     (fway_q),
        .dirty_we     (tag_dirty),
        .dirty_way    (hway)
    );

    logic                dwe, dway;
    logic [BEAT_W-1:0]   dbeat;
    logic [QW_BYTES-1:0] dbe;
    logic [QW_BITS-1:0]  dwdata, drdata;

    dcache_data #(.IDX_W(IDX_W), .BEAT_W(BEAT_W)) u_data (
        .clk     (clk),
        .rd_way  (hway),
        .rd_idx  (idx),
        .rd_beat (qsel),
        .rd_data (drdata),
        .we      (dwe),
        .wr_way  (dway),
        .wr_idx  (idx),
        .wr_beat (dbeat),
        .wr_be   (dbe),
        .wr_data (dwdata)
    );

    assign cpu_req_ready = (st_q == ST_IDLE);
    assign cpu_rsp_valid = rsp_v_q;
    assign cpu_rsp_rdata = rsp_d_q;

    always_comb begin
        st_d          = st_q;
        beat_d        = beat_q;
        fway_d        = fway_q;
        rsp_v_d       = 1'b0;
        rsp_d_d       = rsp_d_q;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = {tag, idx, beat_q, {OFF_W{1'b0}}};
        mem_req_be    = '1;
        mem_req_wdata = wshift;
        dwe           = 1'b0;
        dway          = hway;
        dbeat         = qsel;
        dbe           = be;
        dwdata        = wshift;
        tag_fill      = 1'b0;
        tag_dirty     = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (cpu_req_valid) st_d = ST_LOOK;
            end
            ST_LOOK: begin
                if (!cache_en) begin
                    st_d = ST_BYP_REQ;
                end else if (|hit) begin
                    if (w_q) begin
                        dwe       = 1'b1;
                        tag_dirty = 1'b1;
                        rsp_d_d   = '0;
                    end else begin
                        rsp_d_d   = align_read(drdata, sz_q, off);
                    end
                    rsp_v_d = 1'b1;
                    st_d    = ST_IDLE;
                end else if (victim_dirty) begin
                    st_d = ST_BYP_REQ;
                end else begin
                    fway_d = victim;
                    beat_d = '0;
                    st_d   = ST_FILL_REQ;
                end
            end
            ST_FILL_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) st_d = ST_FILL_WAIT;
            end
            ST_FILL_WAIT: begin
                if (mem_rsp_valid) begin
                    dwe    = 1'b1;
                    dway   = fway_q;
                    dbeat  = beat_q;
                    dbe    = '1;
                    dwdata = mem_rsp_rdata;
                    if (beat_q == BEAT_W'(BEATS - 1)) begin
                        tag_fill = 1'b1;
                        st_d     = ST_LOOK;
                    end else begin
                        beat_d = beat_q + 1'b1;
                        st_d   = ST_FILL_REQ;
                    end
                end
            end
            ST_BYP_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = w_q;
                mem_req_addr  = {a_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                mem_req_be    = be;
                if (mem_req_ready) begin
                    if (w_q) begin
                        rsp_v_d = 1'b1;
                        rsp_d_d = '0;
                        st_d    = ST_IDLE;
                    end else begin
                        st_d = ST_BYP_WAIT;
                    end
                end
            end
            ST_BYP_WAIT: begin
                if (mem_rsp_valid) begin
                    rsp_v_d = 1'b1;
                    rsp_d_d = align_read(mem_rsp_rdata, sz_q, off);
                    st_d    = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            beat_q  <= '0;
            fway_q  <= 1'b0;
            rsp_v_q <= 1'b0;
            rsp_d_q <= '0;
            a_q     <= '0;
            w_q     <= 1'b0;
            sz_q    <= SZ_BYTE;
            wd_q    <= '0;
        end else begin
            st_q    <= st_d;
            beat_q  <= beat_d;
            fway_q  <= fway_d;
            rsp_v_q <= rsp_v_d;
            rsp_d_q <= rsp_d_d;
            if (cpu_req_valid && cpu_req_ready) begin
                a_q  <= cpu_req_addr;
                w_q  <= cpu_req_write;
                sz_q <= acc_size_e'(cpu_req_size);
                wd_q <= cpu_req_wdata;
            end
        end
    end

    // R10: the response strobe lasts a single cycle
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        cpu_rsp_valid |=> !cpu_rsp_valid);

    // R10: after an acceptance no further request is taken the next cycle
    p_accept_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

    // R10: a stalled memory request is held unchanged
    p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    // R9: a byte load carries nothing above bit 7
    p_byte_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (cpu_rsp_valid && sz_q == SZ_BYTE) |-> (cpu_rsp_rdata[127:8] == '0));

endmodule

// File: tb/wb_dcache_test.sv
`timescale 1ns/1ps
module wb_dcache_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         cache_en;
    logic         cpu_req_valid, cpu_req_ready, cpu_req_write;
    logic [2:0]   cpu_req_size;
    logic [31:0]  cpu_req_addr;
    logic [127:0] cpu_req_wdata;
    logic         cpu_rsp_valid;
    logic [127:0] cpu_rsp_rdata;
    logic         mem_req_valid, mem_req_ready, mem_req_write;
    logic [31:0]  mem_req_addr;
    logic [15:0]  mem_req_be;
    logic [127:0] mem_req_wdata;
    logic         mem_rsp_valid = 1'b0;
    logic [127:0] mem_rsp_rdata = '0;

    always #4 clk = ~clk;

    wb_dcache uut (
        .clk(clk), .rst(rst), .cache_en(cache_en),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_size(cpu_req_size),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_be(mem_req_be), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    int errors = 0;
    int checks = 0;

    // ---------------- memory model ----------------
    logic [7:0]  bmem [logic [31:0]];
    logic [7:0]  view [logic [31:0]];
    logic        stall = 1'b0;
    logic        tgl = 1'b0;
    int          n_rd = 0, n_wr = 0;
    logic [31:0] rd_log [64];
    logic [31:0] wr_addr;
    logic [15:0] wr_be;

    assign mem_req_ready = !stall || tgl;

    function automatic logic [7:0] pat(logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] mbyte(logic [31:0] a);
        return bmem.exists(a) ? bmem[a] : pat(a);
    endfunction

    function automatic logic [7:0] vbyte(logic [31:0] a);
        return view.exists(a) ? view[a] : mbyte(a);
    endfunction

    function automatic int nbytes(logic [2:0] sz);
        return (sz >= 3'd4) ? 16 : (1 << sz);
    endfunction

    function automatic logic [127:0] exp_view(logic [2:0] sz, logic [31:0] a);
        logic [127:0] r = '0;
        for (int i = 0; i < nbytes(sz); i++) r[8*i +: 8] = vbyte(a + i);
        return r;
    endfunction

    function automatic logic [127:0] exp_mem(logic [2:0] sz, logic [31:0] a);
        logic [127:0] r = '0;
        for (int i = 0; i < nbytes(sz); i++) r[8*i +: 8] = mbyte(a + i);
        return r;
    endfunction

    always @(posedge clk) begin
        tgl <= ~tgl;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                for (int b = 0; b < 16; b++)
                    if (mem_req_be[b]) bmem[mem_req_addr + b] = mem_req_wdata[8*b +: 8];
                wr_addr = mem_req_addr;
                wr_be   = mem_req_be;
                n_wr++;
            end else begin
                logic [127:0] q;
                for (int b = 0; b < 16; b++) q[8*b +: 8] = mbyte(mem_req_addr + b);
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= q;
                rd_log[n_rd[5:0]] = mem_req_addr;
                n_rd++;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_op(input logic w, input logic [2:0] sz, input logic [31:0] a,
                          input logic [127:0] wd, output logic [127:0] rd,
                          output int lat, output int nr, output int nw);
        int r0, w0;
        @(negedge clk);
        while (!cpu_req_ready) @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = w;
        cpu_req_size  = sz;
        cpu_req_addr  = a;
        cpu_req_wdata = wd;
        r0 = n_rd;
        w0 = n_wr;
        @(posedge clk);
        #1 cpu_req_valid = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_rsp_valid && lat < 5000);
        rd = cpu_rsp_rdata;
        nr = n_rd - r0;
        nw = n_wr - w0;
        if (w) for (int i = 0; i < nbytes(sz); i++) view[a + i] = wd[8*i +: 8];
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1 ready after reset", 128'(cpu_req_ready), 128'd1);
        chk("R1 no response after reset", 128'(cpu_rsp_valid), 128'd0);
        chk("R1 no memory request after reset", 128'(mem_req_valid), 128'd0);
    endtask

    task automatic t_fill_hit();
        logic [127:0] rd;
        int lat, nr, nw, base;
        base = n_rd;
        cpu_op(1'b0, 3'd2, 32'h0000_5048, '0, rd, lat, nr, nw);
        chk("R1 first access misses, R4 four fill reads", 128'(nr), 128'd4);
        for (int k = 0; k < 4; k++)
            chk("R4 R2 fill beat address order", 128'(rd_log[6'(base + k)]), 128'(32'h0000_5040 + 16 * k));
        chk("R4 R9 word from filled line", rd, exp_view(3'd2, 32'h0000_5048));
        cpu_op(1'b0, 3'd0, 32'h0000_5063, '0, rd, lat, nr, nw);
        chk("R3 hit makes no memory read", 128'(nr), 128'd0);
        chk("R3 hit latency", 128'(lat), 128'd2);
        chk("R9 R2 byte read at lane 3 of quadword 2", rd, exp_view(3'd0, 32'h0000_5063));
        cpu_op(1'b0, 3'd4, 32'h0000_5070, '0, rd, lat, nr, nw);
        chk("R2 R9 quadword read", rd, exp_view(3'd4, 32'h0000_5070));
    endtask

    task automatic t_write_merge();
        logic [127:0] rd;
        int lat, nr, nw;
        cpu_op(1'b1, 3'd1, 32'h0000_5056, {112'hDEAD_0000_FFFF_1234_5678_9ABC_DEF0, 16'hBEEF}, rd, lat, nr, nw);
        chk("R6 write hit makes no memory traffic", 128'(nr + nw), 128'd0);
        chk("R9 write returns zero", rd, '0);
        cpu_op(1'b0, 3'd3, 32'h0000_5050, '0, rd, lat, nr, nw);
        chk("R6 halfword merged, neighbours kept", rd, exp_view(3'd3, 32'h0000_5050));
        cpu_op(1'b0, 3'd1, 32'h0000_5056, '0, rd, lat, nr, nw);
        chk("R6 R9 halfword readback", rd, 128'h0000_BEEF);
    endtask

    task automatic t_replace();
        logic [127:0] rd;
        int lat, nr, nw;
        cpu_op(1'b0, 3'd2, 32'h0000_1080, '0, rd, lat, nr, nw);
        chk("R5 X fills", 128'(nr), 128'd4);
        cpu_op(1'b0, 3'd2, 32'h0000_2080, '0, rd, lat, nr, nw);
        chk("R5 Y fills other way", 128'(nr), 128'd4);
        cpu_op(1'b0, 3'd2, 32'h0000_3080, '0, rd, lat, nr, nw);
        chk("R5 Z fills", 128'(nr), 128'd4);
        cpu_op(1'b0, 3'd2, 32'h0000_2080, '0, rd, lat, nr, nw);
        chk("R5 Y survived, Z replaced way 0", 128'(nr), 128'd0);
        cpu_op(1'b0, 3'd2, 32'h0000_1080, '0, rd, lat, nr, nw);
        chk("R5 X evicted earlier, refills", 128'(nr), 128'd4);
        cpu_op(1'b0, 3'd2, 32'h0000_3080, '0, rd, lat, nr, nw);
        chk("R5 Z still in way 0", 128'(nr), 128'd0);
        cpu_op(1'b0, 3'd2, 32'h0000_2080, '0, rd, lat, nr, nw);
        chk("R5 Y replaced by X", 128'(nr), 128'd4);
        chk("R5 Y data after refill", rd, exp_view(3'd2, 32'h0000_2080));
    endtask

    task automatic t_bypass();
        logic [127:0] rd;
        int lat, nr, nw;
        cpu_op(1'b1, 3'd2, 32'h0000_10C0, 128'hCAFE_F00D, rd, lat, nr, nw);
        chk("R6 write miss fills", 128'(nr), 128'd4);
        chk("R6 write miss no memory write", 128'(nw), 128'd0);
        cpu_op(1'b0, 3'd2, 32'h0000_20C0, '0, rd, lat, nr, nw);
        chk("R5 second line fills way 1", 128'(nr), 128'd4);
        cpu_op(1'b1, 3'd2, 32'h0000_30C4, 128'h1357_9BDF, rd, lat, nr, nw);
        chk("R7 dirty victim write goes to memory", 128'(nw), 128'd1);
        chk("R7 dirty victim write makes no fill", 128'(nr), 128'd0);
        chk("R7 write address quadword aligned", 128'(wr_addr), 128'h30C0);
        chk("R7 write byte enables", 128'(wr_be), 128'h00F0);
        cpu_op(1'b0, 3'd2, 32'h0000_30C4, '0, rd, lat, nr, nw);
        chk("R7 dirty victim read is one memory read", 128'(nr), 128'd1);
        chk("R7 uncached read data", rd, 128'h1357_9BDF);
        cpu_op(1'b0, 3'd2, 32'h0000_10C0, '0, rd, lat, nr, nw);
        chk("R7 dirty line left in cache", 128'(nr), 128'd0);
        chk("R7 R6 dirty line keeps written data", rd, 128'hCAFE_F00D);
        cpu_op(1'b0, 3'd2, 32'h0000_20C0, '0, rd, lat, nr, nw);
        chk("R7 clean neighbour still hits", 128'(nr), 128'd0);
    endtask

    task automatic t_disabled();
        logic [127:0] rd;
        int lat, nr, nw;
        cache_en = 1'b0;
        cpu_op(1'b0, 3'd2, 32'h0000_10C0, '0, rd, lat, nr, nw);
        chk("R8 disabled read of cached line goes to memory", 128'(nr), 128'd1);
        chk("R8 disabled read returns memory copy", rd, exp_mem(3'd2, 32'h0000_10C0));
        cpu_op(1'b1, 3'd3, 32'h0000_1148, 128'h0102_0304_0506_0708, rd, lat, nr, nw);
        chk("R8 disabled write is one memory write", 128'(nw), 128'd1);
        chk("R8 disabled write byte enables", 128'(wr_be), 128'hFF00);
        cache_en = 1'b1;
        cpu_op(1'b0, 3'd3, 32'h0000_1148, '0, rd, lat, nr, nw);
        chk("R8 write while disabled did not allocate", 128'(nr), 128'd4);
        chk("R8 data visible after enable", rd, 128'h0102_0304_0506_0708);
    endtask

    task automatic t_stall_b2b();
        logic [127:0] rd, r1;
        int lat, nr, nw, t;
        stall = 1'b1;
        cpu_op(1'b0, 3'd4, 32'h0000_7180, '0, rd, lat, nr, nw);
        chk("R10 fill under memory stalls", 128'(nr), 128'd4);
        chk("R10 stalled fill data", rd, exp_view(3'd4, 32'h0000_7180));
        stall = 1'b0;
        // first request: byte read hit
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_size = 3'd0;
        cpu_req_addr = 32'h0000_7181; cpu_req_wdata = '0;
        @(posedge clk);
        #1 cpu_req_valid = 1'b0;
        t = 0;
        do begin @(negedge clk); t++; end while (!cpu_rsp_valid && t < 100);
        r1 = cpu_rsp_rdata;
        chk("R10 ready high in response cycle", 128'(cpu_req_ready), 128'd1);
        chk("R9 back-to-back first byte", r1, exp_view(3'd0, 32'h0000_7181));
        // second request accepted in the response cycle
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_size = 3'd2;
        cpu_req_addr = 32'h0000_7188; cpu_req_wdata = 128'hA5A5_5A5A;
        @(posedge clk);
        #1 cpu_req_valid = 1'b0;
        @(negedge clk);
        chk("R10 response is a single pulse", 128'(cpu_rsp_valid), 128'd0);
        chk("R10 accepted request makes block busy", 128'(cpu_req_ready), 128'd0);
        t = 0;
        while (!cpu_rsp_valid && t < 100) begin @(negedge clk); t++; end
        chk("R10 second response arrives", 128'(cpu_rsp_valid), 128'd1);
        for (int i = 0; i < 4; i++) view[32'h0000_7188 + i] = 8'(32'hA5A5_5A5A >> (8 * i));
        cpu_op(1'b0, 3'd4, 32'h0000_7180, '0, rd, lat, nr, nw);
        chk("R6 R10 merged quadword after chained write", rd, exp_view(3'd4, 32'h0000_7180));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cache_en = 1'b1;
        cpu_req_valid = 1'b0;
        cpu_req_write = 1'b0;
        cpu_req_size = 3'd0;
        cpu_req_addr = '0;
        cpu_req_wdata = '0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill_hit();
        t_write_merge();
        t_replace();
        t_bypass();
        t_disabled();
        t_stall_b2b();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule